// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block forms the second operand of a load/store RISC datapath. It takes a register value, optionally corrects it when the register read is the program counter, and shifts or rotates it by an amount that comes either from a small immediate field or from the low byte of another register. Alongside the shifted value it produces the shifter carry-out, which the ALU uses when a logical operation updates its flags.

The block is purely combinational. The shift kind is a 3-bit code. Each kind has its own rules at the edges of the amount range: zero, a partial shift, exactly the data width, and beyond the data width. A separate rotate-through-carry mode moves the incoming carry flag into the top bit. When no shift takes place, the carry-out is the incoming carry flag.

Top module: `bshift_unit`

## Requirements
- R1: The shift kind codes are 0 shift-left, 1 logical shift-right, 2 arithmetic shift-right, 3 rotate-right and 4 rotate-right-through-carry. Codes 5 to 7 return the operand unchanged and pass `carry_in` to `carry_out`.
- R2: For kinds 0 to 3, an effective amount of zero returns the operand unchanged and passes `carry_in` to `carry_out`.
- R3: A shift-left by n, with n from 1 to 32, returns the operand shifted left by n with zeros filled in. The carry-out is operand bit 32−n.
- R4: A logical shift-right by n, with n from 1 to 32, returns the operand shifted right by n with zeros filled in. The carry-out is operand bit n−1.
- R5: A shift-left or logical shift-right by more than 32 returns zero with a carry-out of 0.
- R6: An arithmetic shift-right by n, with n from 1 to 31, fills the vacated upper bits with operand bit 31. The carry-out is operand bit n−1.
- R7: An arithmetic shift-right by 32 or more returns 32 copies of operand bit 31. The carry-out equals operand bit 31.
- R8: A rotate-right by a nonzero n rotates by n modulo 32. The carry-out equals bit 31 of the result, so a nonzero multiple of 32 returns the operand with carry-out equal to its bit 31.
- R9: Rotate-through-carry ignores the amount. The result is `carry_in` placed in bit 31 above operand bits 31..1, and the carry-out is operand bit 0.
- R10: When `amt_from_reg` is 1, only bits 7..0 of `amt_reg` form the amount and the upper bits have no effect. When `amt_from_reg` is 0, the 5-bit `amt_imm` is the amount and `amt_reg` has no effect.
- R11: When `src_index` is 15, the operand is `src_value` plus 8 if `narrow_mode` is 0, or plus 4 if `narrow_mode` is 1. For any other index the operand is `src_value` unchanged. The adjusted operand feeds both the result and the carry-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_value | input | 32 | Register value to be shifted |
| src_index | input | 4 | Index of the register that supplied `src_value` |
| narrow_mode | input | 1 | 1 when executing 16-bit instructions, 0 for 32-bit instructions |
| shift_kind | input | 3 | Shift kind code (see R1) |
| amt_from_reg | input | 1 | Selects the register amount (1) or the immediate amount (0) |
| amt_imm | input | 5 | Immediate shift amount |
| amt_reg | input | 32 | Register holding the shift amount; only its low byte is used |
| carry_in | input | 1 | Current carry flag |
| shift_result | output | 32 | Shifted or rotated operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The program-counter correction and the edge-of-range shift rules can act on the same operand at once. The question is whether the carry-out at an exact-width or over-width amount is taken from the corrected value rather than the raw register. Directed vectors therefore select index 15 in both instruction widths together with amounts 0, 1, 31, 32 and 33 and values whose low or high bits change when the offset is added. The random stream draws the index over its full range and biases amounts toward those same boundaries, with random upper bits in the amount register. Every vector is compared against a bit-by-bit reference model in the bench, which applies the offset before it shifts.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

   typedef enum logic [2:0] {
      SK_LSL = 3'd0,
      SK_LSR = 3'd1,
      SK_ASR = 3'd2,
      SK_ROR = 3'd3,
      SK_RRX = 3'd4
   } shift_kind_e;

   // Where the effective amount falls relative to the data width
   typedef enum logic [1:0] {
      AR_ZERO = 2'd0,   // no shift
      AR_PART = 2'd1,   // 1 .. width-1
      AR_FULL = 2'd2,   // exactly width
      AR_OVER = 2'd3    // beyond width
   } amt_range_e;

   localparam int KIND_W = 3;

endpackage

// File: rtl/bshift_operand_adj.sv
module bshift_operand_adj #(
   parameter int DATA_W       = 32,
   parameter int IDX_W        = 4,
   parameter int PC_IDX       = 15,
   parameter int WIDE_BYTES   = 4,
   parameter int NARROW_BYTES = 2
) (
   input  logic [DATA_W-1:0] reg_value,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic              narrow_mode,
   output logic [DATA_W-1:0] eff_value
);

   // A PC read sees the address two instructions ahead
   localparam logic [DATA_W-1:0] WIDE_OFS   = DATA_W'(2 * WIDE_BYTES);
   localparam logic [DATA_W-1:0] NARROW_OFS = DATA_W'(2 * NARROW_BYTES);
   localparam logic [IDX_W-1:0]  PC_SEL     = IDX_W'(PC_IDX);

   logic              is_pc;
   logic [DATA_W-1:0] pc_ofs;

   assign is_pc     = (reg_idx == PC_SEL);
   assign pc_ofs    = narrow_mode ? NARROW_OFS : WIDE_OFS;
   assign eff_value = is_pc ? (reg_value + pc_ofs) : reg_value;

endmodule

// File: rtl/bshift_amount.sv
module bshift_amount
   import bshift_pkg::*;
#(
   parameter  int DATA_W = 32,
   parameter  int AMT_W  = 8,
   localparam int LOG_W  = $clog2(DATA_W)
) (
   input  logic              amt_from_reg,
   input  logic [LOG_W-1:0]  amt_imm,
   input  logic [DATA_W-1:0] amt_reg,
   output logic [LOG_W-1:0]  amt_lo,
   output amt_range_e        amt_range
);

   localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(DATA_W);

   logic [AMT_W-1:0] amt_full;
   logic             unused_amt_hi;

   // Only the low AMT_W bits of a register amount count
   assign amt_full      = amt_from_reg ? amt_reg[AMT_W-1:0] : AMT_W'(amt_imm);
   assign unused_amt_hi = ^amt_reg[DATA_W-1:AMT_W];
   assign amt_lo        = amt_full[LOG_W-1:0];

   always_comb begin
      if (amt_full == '0)
         amt_range = AR_ZERO;
      else if (amt_full < WIDTH_AMT)
         amt_range = AR_PART;
      else if (amt_full == WIDTH_AMT)
         amt_range = AR_FULL;
      else
         amt_range = AR_OVER;
   end

endmodule

// File: rtl/bshift_rotator.sv
module bshift_rotator #(
   parameter  int DATA_W   = 32,
   parameter  int ROT_IMPL = 0,
   localparam int LOG_W    = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [LOG_W-1:0]  rot,
   output logic [DATA_W-1:0] dout
);

   // Rotate right by rot positions
   generate
      if (ROT_IMPL == 0) begin : g_staged
         logic [LOG_W:0][DATA_W-1:0] stg;
         assign stg[0] = din;
         for (genvar s = 0; s < LOG_W; s++) begin : g_stage
            localparam int SH = 1 << s;
            assign stg[s+1] = rot[s] ? {stg[s][SH-1:0], stg[s][DATA_W-1:SH]}
                                     : stg[s];
         end
         assign dout = stg[LOG_W];
      end else begin : g_operator
         logic [2*DATA_W-1:0] dbl;
         assign dbl  = {din, din} >> rot;
         assign dout = dbl[DATA_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/bshift_core.sv
module bshift_core
   import bshift_pkg::*;
#(
   parameter  int DATA_W   = 32,
   parameter  int ROT_IMPL = 0,
   localparam int LOG_W    = $clog2(DATA_W)
) (
   input  logic [KIND_W-1:0] kind,
   input  logic [DATA_W-1:0] opnd,
   input  logic [LOG_W-1:0]  amt_lo,
   input  amt_range_e        amt_range,
   input  logic              cin,
   output logic [DATA_W-1:0] result,
   output logic              cout
);

   localparam logic [DATA_W-1:0] ONES = '1;

   logic [LOG_W-1:0]  rot_k;
   logic [LOG_W-1:0]  below_idx;
   logic [DATA_W-1:0] rotated;
   logic [DATA_W-1:0] keep_hi;
   logic [DATA_W-1:0] keep_lo;
   logic              sign;

   // Left shifts reuse the right rotator: rotate right by (-n mod width)
   assign rot_k     = (kind == SK_LSL) ? (LOG_W'(0) - amt_lo) : amt_lo;
   assign below_idx = amt_lo - LOG_W'(1);
   assign keep_hi   = ONES << amt_lo;
   assign keep_lo   = ONES >> amt_lo;
   assign sign      = opnd[DATA_W-1];

   bshift_rotator #(
      .DATA_W   (DATA_W),
      .ROT_IMPL (ROT_IMPL)
   ) u_rot (
      .din  (opnd),
      .rot  (rot_k),
      .dout (rotated)
   );

   always_comb begin
      result = opnd;
      cout   = cin;
      if (kind == SK_RRX) begin
         result = {cin, opnd[DATA_W-1:1]};
         cout   = opnd[0];
      end else if (amt_range != AR_ZERO) begin
         case (kind)
            SK_LSL: begin
               if (amt_range == AR_PART) begin
                  result = rotated & keep_hi;
                  cout   = opnd[rot_k];
               end else if (amt_range == AR_FULL) begin
                  result = '0;
                  cout   = opnd[0];
               end else begin
                  result = '0;
                  cout   = 1'b0;
               end
            end
            SK_LSR: begin
               if (amt_range == AR_PART) begin
                  result = rotated & keep_lo;
                  cout   = opnd[below_idx];
               end else if (amt_range == AR_FULL) begin
                  result = '0;
                  cout   = sign;
               end else begin
                  result = '0;
                  cout   = 1'b0;
               end
            end
            SK_ASR: begin
               if (amt_range == AR_PART) begin
                  result = (rotated & keep_lo) | (sign ? ~keep_lo : '0);
                  cout   = opnd[below_idx];
               end else begin
                  result = {DATA_W{sign}};
                  cout   = sign;
               end
            end
            SK_ROR: begin
               result = rotated;
               cout   = rotated[DATA_W-1];
            end
            default: begin
               result = opnd;
               cout   = cin;
            end
         endcase
      end
   end

endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
   import bshift_pkg::*;
#(
   parameter  int DATA_W       = 32,
   parameter  int AMT_W        = 8,
   parameter  int IDX_W        = 4,
   parameter  int PC_IDX       = 15,
   parameter  int WIDE_BYTES   = 4,
   parameter  int NARROW_BYTES = 2,
   parameter  int ROT_IMPL     = 0,
   localparam int LOG_W        = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] src_value,
   input  logic [IDX_W-1:0]  src_index,
   input  logic              narrow_mode,
   input  logic [KIND_W-1:0] shift_kind,
   input  logic              amt_from_reg,
   input  logic [LOG_W-1:0]  amt_imm,
   input  logic [DATA_W-1:0] amt_reg,
   input  logic              carry_in,
   output logic [DATA_W-1:0] shift_result,
   output logic              carry_out
);

   // Elaboration-time parameter checks
   generate
      if ((DATA_W < 4) || ((1 << LOG_W) != DATA_W)) begin : g_bad_width
         $error("bshift_unit: DATA_W must be a power of two of at least 4");
      end
      if ((AMT_W <= LOG_W) || (AMT_W >= DATA_W)) begin : g_bad_amt
         $error("bshift_unit: AMT_W must exceed log2(DATA_W) and be below DATA_W");
      end
      if ((PC_IDX < 0) || (PC_IDX >= (1 << IDX_W))) begin : g_bad_pc
         $error("bshift_unit: PC_IDX does not fit in IDX_W bits");
      end
      if ((ROT_IMPL != 0) && (ROT_IMPL != 1)) begin : g_bad_impl
         $error("bshift_unit: ROT_IMPL must be 0 or 1");
      end
   endgenerate

   logic [DATA_W-1:0] opnd;
   logic [LOG_W-1:0]  amt_lo;
   amt_range_e        amt_range;

   bshift_operand_adj #(
      .DATA_W       (DATA_W),
      .IDX_W        (IDX_W),
      .PC_IDX       (PC_IDX),
      .WIDE_BYTES   (WIDE_BYTES),
      .NARROW_BYTES (NARROW_BYTES)
   ) u_adj (
      .reg_value   (src_value),
      .reg_idx     (src_index),
      .narrow_mode (narrow_mode),
      .eff_value   (opnd)
   );

   bshift_amount #(
      .DATA_W (DATA_W),
      .AMT_W  (AMT_W)
   ) u_amt (
      .amt_from_reg (amt_from_reg),
      .amt_imm      (amt_imm),
      .amt_reg      (amt_reg),
      .amt_lo       (amt_lo),
      .amt_range    (amt_range)
   );

   bshift_core #(
      .DATA_W   (DATA_W),
      .ROT_IMPL (ROT_IMPL)
   ) u_core (
      .kind      (shift_kind),
      .opnd      (opnd),
      .amt_lo    (amt_lo),
      .amt_range (amt_range),
      .cin       (carry_in),
      .result    (shift_result),
      .cout      (carry_out)
   );

endmodule

// File: rtl/bshift_unit_chk.sv
module bshift_unit_chk #(
   parameter  int DATA_W = 32,
   parameter  int AMT_W  = 8,
   parameter  int IDX_W  = 4,
   parameter  int PC_IDX = 15,
   localparam int LOG_W  = $clog2(DATA_W)
) (
   input logic [DATA_W-1:0] src_value,
   input logic [IDX_W-1:0]  src_index,
   input logic [2:0]        shift_kind,
   input logic              amt_from_reg,
   input logic [LOG_W-1:0]  amt_imm,
   input logic [DATA_W-1:0] amt_reg,
   input logic              carry_in,
   input logic [DATA_W-1:0] shift_result,
   input logic              carry_out
);

   logic             raw_operand;
   logic             zero_amount;
   logic [AMT_W-1:0] reg_amt;

   assign raw_operand = (src_index != IDX_W'(PC_IDX));
   assign reg_amt     = amt_reg[AMT_W-1:0];
   assign zero_amount = amt_from_reg ? (reg_amt == '0) : (amt_imm == '0);

   always_comb begin
      // R1: unassigned codes leave operand and carry alone
      if ((shift_kind > 3'd4) && raw_operand)
         assert_bad_code_pass_R1: assert ((shift_result == src_value) && (carry_out == carry_in))
            else $error("R1 pass-through violated");

      // R2: zero amount on a real shift kind
      if ((shift_kind < 3'd4) && zero_amount && raw_operand)
         assert_zero_amt_pass_R2: assert ((shift_result == src_value) && (carry_out == carry_in))
            else $error("R2 zero amount violated");

      // R5: logical shifts beyond the width clear everything
      if ((shift_kind < 3'd2) && amt_from_reg && (int'(reg_amt) > DATA_W))
         assert_logic_overrange_R5: assert ((shift_result == '0) && !carry_out)
            else $error("R5 over-range violated");

      // R6: arithmetic shift keeps the sign bit
      if ((shift_kind == 3'd2) && raw_operand)
         assert_asr_sign_kept_R6: assert (shift_result[DATA_W-1] == src_value[DATA_W-1])
            else $error("R6 sign not kept");

      // R7: arithmetic shift by width or more saturates to the carry
      if ((shift_kind == 3'd2) && amt_from_reg && (int'(reg_amt) >= DATA_W))
         assert_asr_saturate_R7: assert (shift_result == {DATA_W{carry_out}})
            else $error("R7 saturation violated");

      // R8: rotate carry follows the result's top bit
      if ((shift_kind == 3'd3) && !zero_amount)
         assert_ror_carry_top_R8: assert (carry_out == shift_result[DATA_W-1])
            else $error("R8 rotate carry violated");

      // R9: rotate-through-carry
      if ((shift_kind == 3'd4) && raw_operand)
         assert_rrx_carry_R9: assert ((shift_result[DATA_W-1] == carry_in) && (carry_out == src_value[0]))
            else $error("R9 rotate-through-carry violated");
   end

endmodule

bind bshift_unit bshift_unit_chk #(
   .DATA_W (DATA_W),
   .AMT_W  (AMT_W),
   .IDX_W  (IDX_W),
   .PC_IDX (PC_IDX)
) u_chk (
   .src_value    (src_value),
   .src_index    (src_index),
   .shift_kind   (shift_kind),
   .amt_from_reg (amt_from_reg),
   .amt_imm      (amt_imm),
   .amt_reg      (amt_reg),
   .carry_in     (carry_in),
   .shift_result (shift_result),
   .carry_out    (carry_out)
);

// File: tb/bshift_unit_test.sv
`timescale 1ns/1ps
module bshift_unit_test;

   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [W-1:0]  src_value;
   logic [3:0]    src_index;
   logic          narrow_mode;
   logic [2:0]    shift_kind;
   logic          amt_from_reg;
   logic [4:0]    amt_imm;
   logic [W-1:0]  amt_reg;
   logic          carry_in;
   logic [W-1:0]  shift_result;
   logic          carry_out;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   bshift_unit uut (
      .src_value    (src_value),
      .src_index    (src_index),
      .narrow_mode  (narrow_mode),
      .shift_kind   (shift_kind),
      .amt_from_reg (amt_from_reg),
      .amt_imm      (amt_imm),
      .amt_reg      (amt_reg),
      .carry_in     (carry_in),
      .shift_result (shift_result),
      .carry_out    (carry_out)
   );

   // Bit-by-bit reference built from the requirements
   function automatic void ref_shift(input int kind, input logic [W-1:0] v, input int n,
                                     input logic ci, output logic [W-1:0] r, output logic co);
      r  = v;
      co = ci;
      if (kind == 4) begin
         for (int i = 0; i < W - 1; i++) r[i] = v[i+1];
         r[W-1] = ci;
         co     = v[0];
      end else if (kind < 4 && n != 0) begin
         case (kind)
            0: begin
               for (int i = 0; i < W; i++) r[i] = (n <= W && i >= n) ? v[i-n] : 1'b0;
               co = (n <= W) ? v[W-n] : 1'b0;
            end
            1: begin
               for (int i = 0; i < W; i++) r[i] = (i + n < W) ? v[i+n] : 1'b0;
               co = (n <= W) ? v[n-1] : 1'b0;
            end
            2: begin
               for (int i = 0; i < W; i++) r[i] = (i + n < W) ? v[i+n] : v[W-1];
               co = (n <= W) ? v[n-1] : v[W-1];
            end
            default: begin
               for (int i = 0; i < W; i++) r[i] = v[(i + (n % W)) % W];
               co = r[W-1];
            end
         endcase
      end
   endfunction

   function automatic string auto_tag(input int kind, input int n, input int idx);
      if (idx == 15)            return "R11";
      if (kind > 4)             return "R1";
      if (kind == 4)            return "R9";
      if (n == 0)               return "R2";
      if (kind == 3)            return "R8";
      if (kind == 0)            return (n > W) ? "R5" : "R3";
      if (kind == 1)            return (n > W) ? "R5" : "R4";
      return (n >= W) ? "R7" : "R6";
   endfunction

   task automatic apply(input logic [W-1:0] v, input int idx, input bit narrow,
                        input int kind, input bit from_reg, input int imm,
                        input logic [W-1:0] areg, input bit ci, input string tag);
      logic [W-1:0] opnd, exp_r;
      logic         exp_c;
      int           n;
      string        t;
      @(negedge clk);
      src_value    = v;
      src_index    = 4'(idx);
      narrow_mode  = narrow;
      shift_kind   = 3'(kind);
      amt_from_reg = from_reg;
      amt_imm      = 5'(imm);
      amt_reg      = areg;
      carry_in     = ci;
      #1;
      opnd = v;
      if (idx == 15) opnd = v + (narrow ? 32'd4 : 32'd8);
      n = from_reg ? int'(areg[7:0]) : (imm & 31);
      ref_shift(kind, opnd, n, ci, exp_r, exp_c);
      t = (tag.len() != 0) ? tag : auto_tag(kind, n, idx);
      checks++;
      if (shift_result !== exp_r || carry_out !== exp_c) begin
         fails++;
         $display("FAIL %s: kind=%0d amt=%0d idx=%0d result=%h carry=%b expected result=%h carry=%b",
                  t, kind, n, idx, shift_result, carry_out, exp_r, exp_c);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete, cycles=%0d expected below 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      int seed_dummy;
      seed_dummy   = $urandom(32'h5eed_1234);
      src_value    = '0;
      src_index    = '0;
      narrow_mode  = 1'b0;
      shift_kind   = '0;
      amt_from_reg = 1'b0;
      amt_imm      = '0;
      amt_reg      = '0;
      carry_in     = 1'b0;
      repeat (4) @(posedge clk);
      rst = 1'b0;

      // Idle inputs: zero operand, zero amount (R2)
      apply(32'h0, 0, 0, 0, 0, 0, 32'h0, 0, "R2");
      // R2: zero amount, immediate and register, carry passes
      apply(32'hDEAD_BEEF, 3, 0, 0, 0, 0, 32'h0, 1, "R2");
      apply(32'h8000_0001, 3, 0, 2, 1, 0, 32'hFFFF_FF00, 1, "R2");
      // R3: shift-left boundaries
      apply(32'h8000_0001, 1, 0, 0, 1, 0, 32'd1, 0, "R3");
      apply(32'h0000_0003, 1, 0, 0, 1, 0, 32'd31, 0, "R3");
      apply(32'h0000_0001, 1, 0, 0, 1, 0, 32'd32, 0, "R3");
      // R4: logical right boundaries
      apply(32'h8000_0001, 2, 0, 1, 0, 1, 32'h0, 0, "R4");
      apply(32'h8000_0000, 2, 0, 1, 1, 0, 32'd32, 0, "R4");
      // R5: beyond width
      apply(32'hFFFF_FFFF, 2, 0, 0, 1, 0, 32'd33, 1, "R5");
      apply(32'hFFFF_FFFF, 2, 0, 1, 1, 0, 32'd255, 1, "R5");
      // R6 / R7: arithmetic right
      apply(32'h8000_0010, 4, 0, 2, 0, 4, 32'h0, 0, "R6");
      apply(32'h4000_0000, 4, 0, 2, 0, 31, 32'h0, 1, "R6");
      apply(32'h8000_0000, 4, 0, 2, 1, 0, 32'd32, 0, "R7");
      apply(32'h7FFF_FFFF, 4, 0, 2, 1, 0, 32'd200, 1, "R7");
      // R8: rotate, including multiples of the width
      apply(32'h0000_0001, 5, 0, 3, 0, 1, 32'h0, 0, "R8");
      apply(32'h8000_0000, 5, 0, 3, 1, 0, 32'd32, 0, "R8");
      apply(32'h1234_5678, 5, 0, 3, 1, 0, 32'd68, 1, "R8");
      // R9: rotate-through-carry ignores the amount
      apply(32'h0000_0001, 6, 0, 4, 0, 0, 32'h0, 1, "R9");
      apply(32'hFFFF_FFFE, 6, 0, 4, 1, 0, 32'd77, 0, "R9");
      // R1: undefined codes pass through
      apply(32'hA5A5_A5A5, 7, 0, 5, 0, 3, 32'h0, 1, "R1");
      apply(32'h5A5A_5A5A, 7, 0, 7, 1, 0, 32'd9, 0, "R1");
      // R10: upper register bits ignored; register ignored for immediates
      apply(32'h0000_00F0, 8, 0, 0, 1, 0, 32'hFFFF_FF03, 0, "R10");
      apply(32'h0000_00F0, 8, 0, 1, 1, 0, 32'h0000_0100, 1, "R10");
      apply(32'h0000_00F0, 8, 0, 1, 0, 4, 32'h0000_0021, 1, "R10");
      // R11: PC offset in both instruction widths, combined with edge amounts
      apply(32'hFFFF_FFF8, 15, 0, 0, 1, 0, 32'd32, 0, "R11");
      apply(32'h7FFF_FFFC, 15, 1, 2, 1, 0, 32'd32, 0, "R11");
      apply(32'h0000_0000, 15, 0, 1, 0, 4, 32'h0, 0, "R11");
      apply(32'h0000_0000, 15, 1, 3, 0, 0, 32'h0, 1, "R11");
      apply(32'h0000_0000, 14, 1, 3, 0, 0, 32'h0, 1, "R11");

      // Random stream with amounts biased toward the range edges
      for (int k = 0; k < 3000; k++) begin
         logic [W-1:0] areg;
         int pick, base;
         pick = int'($urandom_range(0, 7));
         case (pick)
            0: base = 0;
            1: base = 1;
            2: base = 31;
            3: base = 32;
            4: base = 33;
            default: base = int'($urandom_range(0, 255));
         endcase
         areg = {$urandom() & 32'hFFFF_FF00} | 32'(base);
         apply($urandom(), int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
               int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
               int'($urandom_range(0, 31)), areg, 1'($urandom_range(0, 1)), "");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule